// File: doc/BRIEF.md
# True-Colour Colour-Converter Host Register File

This block sits on the host side of a true-colour digital-to-analogue colour converter. It decodes single-byte reads and writes. A 4-bit register index is formed from two extra select inputs and the two low address bits. The index is built as `{sel_upper[1], sel_upper[0], addr_lo[1:0]}`, with bit 3 at the left. Six of the sixteen indices belong to a standard VGA colour-lookup port. The block forwards these on a passthrough port and does not decode them itself. The remaining indices reach four local command registers, a fixed status value, and two 12-bit cursor position registers.

The command registers drive the outputs that other blocks use. These are the converter width (6 or 8 bit), a pixel depth code, the hardware cursor enable, and the cursor size. Index 0xA is banked. Bit 7 of command register 0 decides whether that index shows a read-only status value or command register 3. Palette data sequencing and the cursor pattern memory live in separate blocks.

Read data is registered. It appears on the clock edge that follows the read request and holds until the next read.

Top module: `rdac_regfile`

## Requirements
- R1: Indices 0, 1, 2, 3, 4 and 7 are forwarded. In the same cycle as the access, `ext_wr`/`ext_rd` pulse with `ext_idx` = index bits 2:0 and `ext_wdata` = `wr_data`. A read of these indices returns the `ext_rdata` sampled in the request cycle.
- R2: An access to any other index never raises `ext_wr` or `ext_rd`.
- R3: Index 6 is command register 0 and reads back as written. `dac_8bit` equals its bit 0.
- R4: When command register 0 bit 7 is 0, a read of index 0xA returns 0x60 and a write to index 0xA changes nothing. When bit 7 is 1, index 0xA reads and writes command register 3.
- R5: `cursor_big` (1 = 64x64, 0 = 32x32) equals command register 3 bit 2.
- R6: Index 8 is command register 1. Bits 6:5 and 4:3 give `pix_depth`, using the codes 0 = 4 bpp, 1 = 8 bpp, 2 = 15 bpp, 3 = 16 bpp and 4 = 32 bpp:
  - field 0: 32 bpp when bit 4 is set, otherwise 8 bpp;
  - field 1: 8 bpp when bit 4 is clear, otherwise 16 bpp when bit 3 is set and 15 bpp when it is clear;
  - field 2: 8 bpp;
  - field 3: 4 bpp.
- R7: Index 9 is command register 2. `cursor_en` is 1 when either of its bits 1:0 is set.
- R8: Cursor X low byte is at index 0xC. Index 0xD holds X bits 11:8 and keeps only the low nibble of the written byte. Y uses 0xE and 0xF in the same way. Reads return the low byte, or the high bits zero-extended.
- R9: After reset all registers are zero:
  - `dac_8bit` = 0, `pix_depth` = 1, `cursor_en` = 0, `cursor_big` = 0;
  - both positions are 0, and `rd_data` = 0x00.
- R10: Indices 5 and 0xB are not served here. Reads of them return 0xFF, and writes to them change nothing.
- R11: `rd_data` changes only on the edge after `rd_en` and holds otherwise. A read and a write to the same index in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_upper | input | 2 | Index bits 3:2 |
| addr_lo | input | 2 | Index bits 1:0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| ext_wr | output | 1 | Passthrough write strobe |
| ext_rd | output | 1 | Passthrough read strobe |
| ext_idx | output | 3 | Passthrough index |
| ext_wdata | output | 8 | Passthrough write byte |
| ext_rdata | input | 8 | Passthrough read byte |
| dac_8bit | output | 1 | Converter width: 1 = 8 bit |
| pix_depth | output | 3 | Pixel depth code |
| cursor_en | output | 1 | Hardware cursor enable |
| cursor_big | output | 1 | 64x64 cursor when 1 |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |

## Verification
A read and a write can land in the same cycle, and the registered read path then competes with the register update. The bench provokes this by raising `rd_en` and `wr_en` together on command register 1. It expects the returned byte to be the old contents, and a read on its own afterwards to return the new byte. Bank switching is a second collision between functions. A write to command register 0 bit 7 decides the meaning of the very next access to index 0xA. The bench judges this by reading 0xA directly after each change of the bank bit.

// File: rtl/rdac_pkg.sv
// Shared types for the colour-converter host register file.
// Assumes byte-wide host data and a 4-bit register index.
package rdac_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;
    localparam int NCMD   = 4;

    // Pixel depth codes presented on pix_depth
    typedef enum logic [2:0] {
        DEPTH_4  = 3'd0,
        DEPTH_8  = 3'd1,
        DEPTH_15 = 3'd2,
        DEPTH_16 = 3'd3,
        DEPTH_32 = 3'd4
    } depth_e;

    // Local register indices
    localparam logic [IDX_W-1:0] IX_CMD0 = 4'h6;
    localparam logic [IDX_W-1:0] IX_CMD1 = 4'h8;
    localparam logic [IDX_W-1:0] IX_CMD2 = 4'h9;
    localparam logic [IDX_W-1:0] IX_BANK = 4'hA;
    localparam logic [IDX_W-1:0] IX_XLO  = 4'hC;
    localparam logic [IDX_W-1:0] IX_XHI  = 4'hD;
    localparam logic [IDX_W-1:0] IX_YLO  = 4'hE;
    localparam logic [IDX_W-1:0] IX_YHI  = 4'hF;

    // Write enables produced by the decoder
    typedef struct packed {
        logic [NCMD-1:0] cmd;     // command registers 3..0
        logic [1:0]      pos_lo;  // [0]=X, [1]=Y low byte
        logic [1:0]      pos_hi;  // [0]=X, [1]=Y high bits
    } wr_sel_t;

    // True for indices owned by the external standard lookup port
    function automatic logic is_pass(input logic [IDX_W-1:0] ix);
        return (ix <= 4'h4) || (ix == 4'h7);
    endfunction

endpackage

// File: rtl/rdac_decode.sv
// Index decoder: turns a write strobe plus index into per-register enables
// and flags passthrough indices. Assumes at most one access index per cycle.
module rdac_decode
    import rdac_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             bank_cmd3,
    output wr_sel_t          we,
    output logic             pass_hit
);

    // Combinational decode of write enables
    always_comb begin
        we          = '0;
        we.cmd[0]   = wr_en && (idx == IX_CMD0);
        we.cmd[1]   = wr_en && (idx == IX_CMD1);
        we.cmd[2]   = wr_en && (idx == IX_CMD2);
        we.cmd[3]   = wr_en && (idx == IX_BANK) && bank_cmd3;
        we.pos_lo[0] = wr_en && (idx == IX_XLO);
        we.pos_hi[0] = wr_en && (idx == IX_XHI);
        we.pos_lo[1] = wr_en && (idx == IX_YLO);
        we.pos_hi[1] = wr_en && (idx == IX_YHI);
    end

    assign pass_hit = is_pass(idx);

endmodule

// File: rtl/rdac_cmd_regs.sv
// Command register bank (four bytes) and the mode outputs derived from them.
// Assumes enables are mutually exclusive; reset clears every register.
module rdac_cmd_regs
    import rdac_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NCMD-1:0]             we,
    output logic [NCMD-1:0][DATA_W-1:0] cr,
    output logic                        dac_8bit,
    output depth_e                      depth,
    output logic                        cur_en,
    output logic                        cur_big
);

    for (genvar g = 0; g < NCMD; g++) begin : g_cr
        // Store one command byte
        always_ff @(posedge clk) begin
            if (!rst_n)     cr[g] <= '0;
            else if (we[g]) cr[g] <= wr_data;
        end
    end

    // Decode pixel depth from command register 1
    always_comb begin
        unique case (cr[1][6:5])
            2'd0:    depth = cr[1][4] ? DEPTH_32 : DEPTH_8;
            2'd1:    depth = !cr[1][4] ? DEPTH_8 : (cr[1][3] ? DEPTH_16 : DEPTH_15);
            2'd2:    depth = DEPTH_8;
            default: depth = DEPTH_4;
        endcase
    end

    assign dac_8bit = cr[0][0];
    assign cur_en   = |cr[2][1:0];
    assign cur_big  = cr[3][2];

endmodule

// File: rtl/rdac_pos_axis.sv
// One cursor position axis: low byte and high bits written separately.
// Assumes POS_W lies between DATA_W+1 and 2*DATA_W.
module rdac_pos_axis
    import rdac_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              we_lo,
    input  logic              we_hi,
    output logic [POS_W-1:0]  pos
);

    localparam int HI_W = POS_W - DATA_W;

    // Update low byte or high bits of the position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else begin
            if (we_lo) pos[DATA_W-1:0]     <= wr_data;
            if (we_hi) pos[POS_W-1:DATA_W] <= wr_data[HI_W-1:0];
        end
    end

endmodule

// File: rtl/rdac_rd_mux.sv
// Read-back selector: chooses the byte returned for the current index.
// Assumes the passthrough read byte is valid in the request cycle.
module rdac_rd_mux
    import rdac_pkg::*;
#(
    parameter int                POS_W      = 12,
    parameter logic [DATA_W-1:0] STATUS_VAL = 8'h60,
    parameter logic [DATA_W-1:0] IDLE_VAL   = 8'hFF
) (
    input  logic [IDX_W-1:0]            idx,
    input  logic                        pass_hit,
    input  logic [DATA_W-1:0]           ext_rdata,
    input  logic [NCMD-1:0][DATA_W-1:0] cr,
    input  logic [POS_W-1:0]            pos_x,
    input  logic [POS_W-1:0]            pos_y,
    output logic [DATA_W-1:0]           rd_val
);

    localparam int HI_W = POS_W - DATA_W;

    logic [DATA_W-1:0] x_hi, y_hi;
    assign x_hi = DATA_W'(pos_x[POS_W-1:DATA_W]);
    assign y_hi = DATA_W'(pos_y[POS_W-1:DATA_W]);

    // Select the byte for the addressed register
    always_comb begin
        rd_val = IDLE_VAL;
        if (pass_hit) begin
            rd_val = ext_rdata;
        end else begin
            unique case (idx)
                IX_CMD0: rd_val = cr[0];
                IX_CMD1: rd_val = cr[1];
                IX_CMD2: rd_val = cr[2];
                IX_BANK: rd_val = cr[0][7] ? cr[3] : STATUS_VAL;
                IX_XLO:  rd_val = pos_x[DATA_W-1:0];
                IX_XHI:  rd_val = x_hi;
                IX_YLO:  rd_val = pos_y[DATA_W-1:0];
                IX_YHI:  rd_val = y_hi;
                default: rd_val = IDLE_VAL;
            endcase
        end
    end

endmodule

// File: rtl/rdac_regfile.sv
// Top of the colour-converter host register file. Builds the register index,
// forwards standard lookup indices, and returns registered read data.
// Assumes single-byte accesses and a synchronous active-low reset.
module rdac_regfile
    import rdac_pkg::*;
#(
    parameter int                POS_W      = 12,
    parameter logic [DATA_W-1:0] STATUS_VAL = 8'h60,
    parameter logic [DATA_W-1:0] IDLE_VAL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_upper,
    input  logic [1:0]        addr_lo,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [2:0]        ext_idx,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              dac_8bit,
    output logic [2:0]        pix_depth,
    output logic              cursor_en,
    output logic              cursor_big,
    output logic [POS_W-1:0]  cursor_x,
    output logic [POS_W-1:0]  cursor_y
);

    logic [IDX_W-1:0]            idx;
    wr_sel_t                     we;
    logic                        pass_hit;
    logic [NCMD-1:0][DATA_W-1:0] cr;
    logic [DATA_W-1:0]           cr0_q;
    depth_e                      depth;
    logic [DATA_W-1:0]           rd_val;
    logic [1:0][POS_W-1:0]       pos;

    assign idx   = {sel_upper, addr_lo};
    assign cr0_q = cr[0];

    rdac_decode i_decode (
        .idx       (idx),
        .wr_en     (wr_en),
        .bank_cmd3 (cr0_q[7]),
        .we        (we),
        .pass_hit  (pass_hit)
    );

    rdac_cmd_regs i_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .we       (we.cmd),
        .cr       (cr),
        .dac_8bit (dac_8bit),
        .depth    (depth),
        .cur_en   (cursor_en),
        .cur_big  (cursor_big)
    );

    for (genvar a = 0; a < 2; a++) begin : g_axis
        rdac_pos_axis #(.POS_W(POS_W)) i_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (wr_data),
            .we_lo   (we.pos_lo[a]),
            .we_hi   (we.pos_hi[a]),
            .pos     (pos[a])
        );
    end

    rdac_rd_mux #(
        .POS_W      (POS_W),
        .STATUS_VAL (STATUS_VAL),
        .IDLE_VAL   (IDLE_VAL)
    ) i_mux (
        .idx       (idx),
        .pass_hit  (pass_hit),
        .ext_rdata (ext_rdata),
        .cr        (cr),
        .pos_x     (pos[0]),
        .pos_y     (pos[1]),
        .rd_val    (rd_val)
    );

    // Register the read byte on each read request
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_val;
    end

    assign ext_wr    = wr_en && pass_hit;
    assign ext_rd    = rd_en && pass_hit;
    assign ext_idx   = idx[2:0];
    assign ext_wdata = wr_data;
    assign pix_depth = depth;
    assign cursor_x  = pos[0];
    assign cursor_y  = pos[1];

endmodule

// File: rtl/rdac_regfile_chk.sv
// Property checker for the host register file, bound to the top module.
// Assumes the default 12-bit position width.
module rdac_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  sel_upper,
    input logic [1:0]  addr_lo,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  rd_data,
    input logic        ext_wr,
    input logic        ext_rd,
    input logic [2:0]  pix_depth,
    input logic        cursor_en,
    input logic        cursor_big,
    input logic [11:0] cursor_x,
    input logic [7:0]  cr0_q
);

    logic [3:0] ci;
    logic       ci_pass;
    assign ci      = {sel_upper, addr_lo};
    assign ci_pass = (ci <= 4'h4) || (ci == 4'h7);

    AST_PASS_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ci_pass) |-> ext_rd); // R1
    AST_NO_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ci_pass) |-> !ext_wr); // R2
    AST_NO_FOREIGN_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ci_pass) |-> !ext_rd); // R2
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ci == 4'hA && !cr0_q[7]) |=> (rd_data == 8'h60)); // R4
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ci == 4'hA && !cr0_q[7]) |=> $stable(cursor_big)); // R4
    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_depth <= 3'd4); // R6
    AST_CEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ci == 4'h9) |=> $stable(cursor_en)); // R7
    AST_XHI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ci == 4'hD) |=> $stable(cursor_x[11:8])); // R8
    AST_UNUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (ci == 4'h5 || ci == 4'hB)) |=> (rd_data == 8'hFF)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11

endmodule

bind rdac_regfile rdac_regfile_chk i_chk (.*);

// File: tb/test_rdac_regfile.sv
`timescale 1ns/1ps
module test_rdac_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel_upper = '0;
    logic [1:0]  addr_lo = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        ext_wr, ext_rd;
    logic [2:0]  ext_idx;
    logic [7:0]  ext_wdata;
    logic [7:0]  ext_rdata;
    logic        dac_8bit;
    logic [2:0]  pix_depth;
    logic        cursor_en, cursor_big;
    logic [11:0] cursor_x, cursor_y;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // External lookup port model: returns a pattern tagged with its index
    assign ext_rdata = {5'b10100, ext_idx};

    rdac_regfile i_rdac_regfile (
        .clk(clk), .rst_n(rst_n), .sel_upper(sel_upper), .addr_lo(addr_lo),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_idx(ext_idx),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .dac_8bit(dac_8bit),
        .pix_depth(pix_depth), .cursor_en(cursor_en), .cursor_big(cursor_big),
        .cursor_x(cursor_x), .cursor_y(cursor_y)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Write one byte; checks passthrough strobe behaviour during the access
    task automatic wr(input logic [3:0] ix, input logic [7:0] d, input string tag);
        @(negedge clk);
        {sel_upper, addr_lo} = ix;
        wr_data = d;
        wr_en = 1'b1;
        #1;
        if ((ix <= 4'h4) || (ix == 4'h7)) begin
            chk({tag, " R1 ext_wr"}, ext_wr, 1);
            chk({tag, " R1 ext_idx"}, ext_idx, ix[2:0]);
            chk({tag, " R1 ext_wdata"}, ext_wdata, d);
        end else begin
            chk({tag, " R2 ext_wr quiet"}, ext_wr, 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix, output logic [7:0] d);
        @(negedge clk);
        {sel_upper, addr_lo} = ix;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R9 dac_8bit", dac_8bit, 0);
        chk("R9 pix_depth", pix_depth, 1);
        chk("R9 cursor_en", cursor_en, 0);
        chk("R9 cursor_big", cursor_big, 0);
        chk("R9 cursor_x", cursor_x, 0);
        chk("R9 cursor_y", cursor_y, 0);
        chk("R9 rd_data", rd_data, 0);
        rd(4'h6, v); chk("R9 cmd0 read", v, 8'h00);
        rd(4'hA, v); chk("R4 status after reset", v, 8'h60);
    endtask

    task automatic t_pass;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            if (i == 5 || i == 6) continue;
            wr(4'(i), 8'(8'h30 + i), "pass");
            rd(4'(i), v);
            chk("R1 pass read", v, {5'b10100, 3'(i)});
        end
    endtask

    task automatic t_bank;
        logic [7:0] v;
        wr(4'hA, 8'h04, "bank0 wr");
        chk("R4 write ignored", cursor_big, 0);
        rd(4'hA, v); chk("R4 still status", v, 8'h60);
        wr(4'h6, 8'h80, "cmd0");
        rd(4'hA, v); chk("R4 cmd3 visible", v, 8'h00);
        wr(4'hA, 8'h04, "cmd3 wr");
        chk("R5 cursor_big set", cursor_big, 1);
        rd(4'hA, v); chk("R4 cmd3 readback", v, 8'h04);
        wr(4'h6, 8'h81, "cmd0");
        chk("R3 dac_8bit", dac_8bit, 1);
        rd(4'h6, v); chk("R3 cmd0 readback", v, 8'h81);
        wr(4'h6, 8'h01, "cmd0");
        rd(4'hA, v); chk("R4 status again", v, 8'h60);
        chk("R5 cursor_big kept", cursor_big, 1);
        wr(4'h6, 8'h80, "cmd0");
        wr(4'hA, 8'h00, "cmd3 clr");
        chk("R5 cursor_big clear", cursor_big, 0);
        chk("R3 dac_8bit clear", dac_8bit, 0);
    endtask

    task automatic t_depth;
        logic [7:0] vals [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h38, 8'h58, 8'h60, 8'h78};
        logic [2:0] exps [8] = '{3'd1, 3'd4, 3'd1, 3'd2, 3'd3, 3'd1, 3'd0, 3'd0};
        for (int i = 0; i < 8; i++) begin
            wr(4'h8, vals[i], "cmd1");
            chk("R6 pix_depth", pix_depth, exps[i]);
        end
    endtask

    task automatic t_cursor_en;
        wr(4'h9, 8'h01, "cmd2"); chk("R7 en bit0", cursor_en, 1);
        wr(4'h9, 8'hFC, "cmd2"); chk("R7 en off", cursor_en, 0);
        wr(4'h9, 8'h02, "cmd2"); chk("R7 en bit1", cursor_en, 1);
    endtask

    task automatic t_pos;
        logic [7:0] v;
        wr(4'hC, 8'h34, "xlo");
        wr(4'hD, 8'hF5, "xhi");
        chk("R8 cursor_x", cursor_x, 12'h534);
        rd(4'hD, v); chk("R8 x high read", v, 8'h05);
        rd(4'hC, v); chk("R8 x low read", v, 8'h34);
        wr(4'hE, 8'hAB, "ylo");
        wr(4'hF, 8'h1C, "yhi");
        chk("R8 cursor_y", cursor_y, 12'hCAB);
        rd(4'hF, v); chk("R8 y high read", v, 8'h0C);
        chk("R8 x untouched", cursor_x, 12'h534);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        wr(4'h5, 8'h12, "idx5");
        wr(4'hB, 8'h34, "idxB");
        rd(4'h5, v); chk("R10 idx5 read", v, 8'hFF);
        rd(4'hB, v); chk("R10 idxB read", v, 8'hFF);
        chk("R10 x unchanged", cursor_x, 12'h534);
        chk("R10 y unchanged", cursor_y, 12'hCAB);
        rd(4'h8, v); chk("R10 cmd1 unchanged", v, 8'h78);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        wr(4'h8, 8'h00, "cmd1");
        @(negedge clk);
        {sel_upper, addr_lo} = 4'h8;
        wr_data = 8'h30;
        wr_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk("R11 same-cycle old value", rd_data, 8'h00);
        repeat (3) @(negedge clk);
        chk("R11 held without read", rd_data, 8'h00);
        rd(4'h8, v); chk("R11 new value", v, 8'h30);
        chk("R6 depth after collide", pix_depth, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_bank();
        t_depth();
        t_cursor_en();
        t_pos();
        t_unused();
        t_collide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule